// File: doc/BRIEF.md
# Reference Holdover and Switching Controller

This block is the control state machine for the first loop of a two-loop clock synthesizer. It chooses which of four input references drives the loop. It waits for the lock indication, and it reacts when the loop loses its reference. In that case it enters holdover: the charge pump is put in a high-impedance state and, when configured, the VCO tuning voltage is forced from a DAC. Once a usable reference is present again, it leaves holdover through a timed settling phase and starts acquiring again.

In automatic mode the controller acts on its own. It ranks the references that are enabled and free of loss of signal, and picks the best one. In manual mode software names the reference and decides on holdover through a force bit. In both modes the current state is visible as a 3-bit code.

Top module: `ref_holdover_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_code` is 0 (INIT), `active_ref` is 0, and `cp_tristate` and `vtune_force` are low.
- R2: After reset is released, the first clock edge moves the state to 1 (PRELOAD) and the next edge moves it to 2 (ACQUIRE).
- R3: In automatic mode, the reference chosen on the edge that leaves PRELOAD, or on the edge that leaves HOLD_STABLE, is the best one. The best reference is enabled (`ref_en[i]`=1), has no loss of signal (`ref_los[i]`=0), and has the lowest rank in `ref_rank[2i+1:2i]`. A tie goes to the lower index.
- R4: From ACQUIRE the state becomes 3 (LOCKED) on the edge where `lock_det` is high, and not before.
- R5: In automatic mode, LOCKED moves to 4 (HOLD_ENTRY) on the next edge when any of the following holds:
  - `lock_det` is low;
  - the active reference shows loss of signal;
  - a valid best reference exists that differs from `active_ref` (a priority clash).
- R6: HOLD_ENTRY always moves to 5 (HOLD_STABLE) on the next edge. In automatic mode, HOLD_STABLE is kept for as long as no reference is valid.
- R7: `cp_tristate` is high exactly in states 4 and 5. `vtune_force` equals `cp_tristate` AND `dac_hold_en`.
- R8: In automatic mode, a valid reference during HOLD_STABLE moves the state to 6 (HOLD_EXIT) and takes that reference as `active_ref`. HOLD_EXIT lasts `settle_len`+1 cycles and then returns to ACQUIRE.
- R9: In manual mode, `active_ref` takes the value of `man_sel` one edge later. Loss of signal and better-ranked references cause no state change.
- R10: In manual mode, `force_hold` high in ACQUIRE or LOCKED leads to HOLD_ENTRY. HOLD_STABLE is held while `force_hold` stays high, and moves to HOLD_EXIT once it is low.
- R11: In manual mode, LOCKED with `lock_det` low and `force_hold` low returns to ACQUIRE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = automatic mode, 0 = manual mode |
| man_sel | input | 2 | Reference selected in manual mode |
| force_hold | input | 1 | Holdover request in manual mode |
| ref_en | input | 4 | Per-reference enable |
| ref_los | input | 4 | Per-reference loss-of-signal flag |
| ref_rank | input | 8 | 2-bit rank per reference; lower is preferred |
| lock_det | input | 1 | Lock indication from the lock detector |
| dac_hold_en | input | 1 | Allows the tuning voltage to be forced in holdover |
| settle_len | input | 8 | Number of extra cycles spent in HOLD_EXIT |
| state_code | output | 3 | Current state code (0..6) |
| active_ref | output | 2 | Index of the active reference |
| cp_tristate | output | 1 | Charge pump high-impedance request |
| vtune_force | output | 1 | Force the tuning voltage from the DAC |

## Verification
The assertions check these properties on every cycle:
- the fixed transition chains INIT→PRELOAD→ACQUIRE and HOLD_ENTRY→HOLD_STABLE;
- the lock guard on entering LOCKED;
- the automatic holdover entry when lock is lost;
- the return from HOLD_EXIT when the settle timer expires;
- manual tracking of `man_sel` and the rule that manual mode never leaves LOCKED on its own;
- that `vtune_force` implies `cp_tristate`.

Only the bench's scenarios can show the following:
- that the ranking picks the correct reference, including ties and disabled references with a good rank;
- the exact length of HOLD_EXIT;
- that holdover persists while every reference is lost.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [2:0] {
        ST_INIT        = 3'd0,
        ST_PRELOAD     = 3'd1,
        ST_ACQUIRE     = 3'd2,
        ST_LOCKED      = 3'd3,
        ST_HOLD_ENTRY  = 3'd4,
        ST_HOLD_STABLE = 3'd5,
        ST_HOLD_EXIT   = 3'd6
    } fsm_state_e;

endpackage

// File: rtl/ref_pick.sv
module ref_pick #(
    parameter int NREF   = 4,
    parameter int RANK_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [NREF-1:0]        ref_en,
    input  logic [NREF-1:0]        ref_los,
    input  logic [NREF*RANK_W-1:0] ref_rank,
    output logic [IDX_W-1:0]       best_idx,
    output logic                   best_ok
);

    logic [NREF-1:0]   cand;
    logic [RANK_W-1:0] rk [NREF];

    genvar g;
    generate
        for (g = 0; g < NREF; g++) begin : g_unpack
            assign cand[g] = ref_en[g] & ~ref_los[g];
            assign rk[g]   = ref_rank[g*RANK_W +: RANK_W];
        end
    endgenerate

    logic [RANK_W-1:0] best_rank;

    // Strict compare: an equal rank never displaces a lower index.
    always_comb begin
        best_idx  = '0;
        best_ok   = 1'b0;
        best_rank = '1;
        for (int i = 0; i < NREF; i++) begin
            if (cand[i] && (!best_ok || rk[i] < best_rank)) begin
                best_ok   = 1'b1;
                best_idx  = IDX_W'(i);
                best_rank = rk[i];
            end
        end
    end

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ref_holdover_ctrl.sv
module ref_holdover_ctrl
    import refsw_pkg::*;
#(
    parameter int NREF     = 4,
    parameter int RANK_W   = 2,
    parameter int SETTLE_W = 8,
    localparam int IDX_W   = $clog2(NREF)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_mode,
    input  logic [IDX_W-1:0]       man_sel,
    input  logic                   force_hold,
    input  logic [NREF-1:0]        ref_en,
    input  logic [NREF-1:0]        ref_los,
    input  logic [NREF*RANK_W-1:0] ref_rank,
    input  logic                   lock_det,
    input  logic                   dac_hold_en,
    input  logic [SETTLE_W-1:0]    settle_len,
    output logic [2:0]             state_code,
    output logic [IDX_W-1:0]       active_ref,
    output logic                   cp_tristate,
    output logic                   vtune_force
);

    typedef struct packed {
        fsm_state_e       state;
        logic [IDX_W-1:0] aref;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [IDX_W-1:0] best_idx;
    logic             best_ok;
    logic             tmr_load;
    logic             tmr_zero;
    logic             clash;

    ref_pick #(.NREF(NREF), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
        .ref_en   (ref_en),
        .ref_los  (ref_los),
        .ref_rank (ref_rank),
        .best_idx (best_idx),
        .best_ok  (best_ok)
    );

    hold_timer #(.W(SETTLE_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_len),
        .run      (ctl_q.state == ST_HOLD_EXIT),
        .zero     (tmr_zero)
    );

    assign clash = best_ok && (best_idx != ctl_q.aref);

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        case (ctl_q.state)
            ST_INIT:    ctl_d.state = ST_PRELOAD;
            ST_PRELOAD: begin
                ctl_d.state = ST_ACQUIRE;
                if (auto_mode) ctl_d.aref = best_idx;
            end
            ST_ACQUIRE: begin
                if (!auto_mode && force_hold) ctl_d.state = ST_HOLD_ENTRY;
                else if (lock_det)            ctl_d.state = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (auto_mode) begin
                    if (!lock_det || ref_los[ctl_q.aref] || clash)
                        ctl_d.state = ST_HOLD_ENTRY;
                end else begin
                    if (force_hold)     ctl_d.state = ST_HOLD_ENTRY;
                    else if (!lock_det) ctl_d.state = ST_ACQUIRE;
                end
            end
            ST_HOLD_ENTRY: ctl_d.state = ST_HOLD_STABLE;
            ST_HOLD_STABLE: begin
                if (auto_mode) begin
                    if (best_ok) begin
                        ctl_d.state = ST_HOLD_EXIT;
                        ctl_d.aref  = best_idx;
                        tmr_load    = 1'b1;
                    end
                end else if (!force_hold) begin
                    ctl_d.state = ST_HOLD_EXIT;
                    tmr_load    = 1'b1;
                end
            end
            ST_HOLD_EXIT: begin
                if (tmr_zero) ctl_d.state = ST_ACQUIRE;
            end
            default: ctl_d.state = ST_INIT;
        endcase
        if (!auto_mode) ctl_d.aref = man_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_INIT, aref: '0};
        else        ctl_q <= ctl_d;
    end

    assign state_code  = ctl_q.state;
    assign active_ref  = ctl_q.aref;
    assign cp_tristate = (ctl_q.state == ST_HOLD_ENTRY) || (ctl_q.state == ST_HOLD_STABLE);
    assign vtune_force = cp_tristate && dac_hold_en;

    AST_INIT_TO_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd0 |=> state_code == 3'd1); // R2
    AST_PRELOAD_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd1 |=> state_code == 3'd2); // R2
    AST_LOCK_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd2 && !lock_det |=> state_code != 3'd3); // R4
    AST_AUTO_LOSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode && state_code == 3'd3 && !lock_det |=> state_code == 3'd4); // R5
    AST_ENTRY_TO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd4 |=> state_code == 3'd5); // R6
    AST_FORCE_NEEDS_TRI: assert property (@(posedge clk) disable iff (!rst_n)
        vtune_force |-> cp_tristate); // R7
    AST_EXIT_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd6 && tmr_zero |=> state_code == 3'd2); // R8
    AST_MANUAL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> active_ref == $past(man_sel)); // R9
    AST_MANUAL_KEEP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode && state_code == 3'd3 && lock_det && !force_hold |=> state_code == 3'd3); // R9
    AST_MANUAL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode && force_hold && state_code == 3'd5 |=> state_code == 3'd5); // R10
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 3'd7); // R2

endmodule

// File: tb/ref_holdover_ctrl_tb.sv
`timescale 1ns/1ps
module ref_holdover_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic [1:0] man_sel = '0;
    logic       force_hold = 1'b0;
    logic [3:0] ref_en = '0;
    logic [3:0] ref_los = '0;
    // ranks: ref3=0, ref2=1, ref1=1, ref0=3
    logic [7:0] ref_rank = 8'b00_01_01_11;
    logic       lock_det = 1'b0;
    logic       dac_hold_en = 1'b1;
    logic [7:0] settle_len = 8'd2;
    logic [2:0] state_code;
    logic [1:0] active_ref;
    logic       cp_tristate;
    logic       vtune_force;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ref_holdover_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .man_sel(man_sel),
        .force_hold(force_hold), .ref_en(ref_en), .ref_los(ref_los),
        .ref_rank(ref_rank), .lock_det(lock_det), .dac_hold_en(dac_hold_en),
        .settle_len(settle_len), .state_code(state_code), .active_ref(active_ref),
        .cp_tristate(cp_tristate), .vtune_force(vtune_force)
    );

    typedef struct packed {
        logic       am;
        logic [1:0] sel;
        logic       frc;
        logic [3:0] en;
        logic [3:0] los;
        logic       lk;
        logic [2:0] est;
        logic [1:0] eref;
        logic       etri;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'h8, 1'b0, 3'd1, 2'd0, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'h8, 1'b0, 3'd2, 2'd1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'h8, 1'b0, 3'd2, 2'd1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'h8, 1'b1, 3'd3, 2'd1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'h0, 1'b1, 3'd4, 2'd1, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hF, 1'b0, 3'd5, 2'd1, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hF, 1'b0, 3'd5, 2'd1, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hB, 1'b0, 3'd6, 2'd2, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hB, 1'b0, 3'd6, 2'd2, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hB, 1'b0, 3'd6, 2'd2, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hB, 1'b0, 3'd2, 2'd2, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hB, 1'b1, 3'd3, 2'd2, 1'b0},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hF, 1'b1, 3'd4, 2'd2, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hF, 1'b0, 3'd5, 2'd2, 1'b1},
        '{1'b1, 2'd0, 1'b0, 4'hF, 4'hE, 1'b0, 3'd6, 2'd0, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd6, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd6, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd2, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b1, 3'd3, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b1, 3'd3, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b1, 4'hF, 4'hF, 1'b1, 3'd4, 2'd3, 1'b1},
        '{1'b0, 2'd3, 1'b1, 4'hF, 4'hF, 1'b1, 3'd5, 2'd3, 1'b1},
        '{1'b0, 2'd3, 1'b1, 4'hF, 4'hF, 1'b1, 3'd5, 2'd3, 1'b1},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b1, 3'd6, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd6, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd6, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd2, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b1, 3'd3, 2'd3, 1'b0},
        '{1'b0, 2'd3, 1'b0, 4'hF, 4'hF, 1'b0, 3'd2, 2'd3, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // R1: state held while reset is low
        check("R1 state", int'(state_code), 0);
        check("R1 active_ref", int'(active_ref), 0);
        check("R1 cp_tristate", int'(cp_tristate), 0);
        check("R1 vtune_force", int'(vtune_force), 0);

        // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            auto_mode  = VECS[i].am;
            man_sel    = VECS[i].sel;
            force_hold = VECS[i].frc;
            ref_en     = VECS[i].en;
            ref_los    = VECS[i].los;
            lock_det   = VECS[i].lk;
            step();
            check($sformatf("R2-R11 vec%0d state", i), int'(state_code), int'(VECS[i].est));
            check($sformatf("R3/R9 vec%0d active_ref", i), int'(active_ref), int'(VECS[i].eref));
            check($sformatf("R7 vec%0d cp_tristate", i), int'(cp_tristate), int'(VECS[i].etri));
            check($sformatf("R7 vec%0d vtune_force", i), int'(vtune_force), int'(VECS[i].etri));
            @(negedge clk);
        end

        // R3: a disabled reference with the best rank is skipped, and a LOS reference too
        do_reset();
        auto_mode = 1'b1; force_hold = 1'b0; lock_det = 1'b0;
        ref_en = 4'b0110; ref_los = 4'b0010;
        rst_n = 1'b1;
        step();
        check("R2 preload", int'(state_code), 1);
        @(negedge clk);
        step();
        check("R3 disabled/los skipped", int'(active_ref), 2);

        // R5: loss of lock alone; R7: vtune held low without DAC enable
        do_reset();
        ref_en = 4'b0001; ref_los = 4'b0000; dac_hold_en = 1'b0;
        rst_n = 1'b1;
        step();
        @(negedge clk);
        step();
        check("R3 single ref", int'(active_ref), 0);
        @(negedge clk);
        lock_det = 1'b1;
        step();
        check("R4 lock", int'(state_code), 3);
        @(negedge clk);
        lock_det = 1'b0;
        step();
        check("R5 loss of lock", int'(state_code), 4);
        check("R7 tri no dac", int'(cp_tristate), 1);
        check("R7 vtune no dac", int'(vtune_force), 0);

        finish_run();
    end

endmodule